// File: doc/BRIEF.md
# Two-Lane Unfolded Lagged-Feedback Recursive Filter

This block evaluates the first-order recurrence y(n) = a·y(n−LAG) + x(n) on a stream of fixed-point samples. The history of y is zero before the first input. It reaches the sample rate with arithmetic that runs at only half that rate. Incoming samples are paired by a serial-to-parallel stage. Two multiply-add lanes then work on each pair together: one lane handles the even-indexed sample and the other handles the odd-indexed sample. A parallel-to-serial stage sends the results out one per cycle, in their original order.

With the default lag of 9 and two lanes, the required history value comes from a different lane and a different depth for each lane. The even lane uses the odd-lane result from 5 pairs earlier. The odd lane uses the even-lane result from 4 pairs earlier. The two feedback delay lines therefore hold 9 pair-rate registers in total, which is the same count as the original recurrence. An even lag uses a different structure, chosen at elaboration: each lane feeds itself through LAG/2 registers.

The coefficient is a Q1.15 input and must be held constant while data flows. Data are Q1.15. Each product is truncated back to Q1.15, and each sum saturates to the signed range.

Top module: `unf2_iir`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) forces out_valid low in the following cycle. It also clears all feedback history, the held even sample and the sample phase.
- R2: out_valid stays low while only the even member of a pair has been accepted. No result leaves before its pair is complete.
- R3: The n-th output equals a·y(n−LAG) + x(n), with LAG = 9 by default. Here x(n) is the n-th accepted input since reset, and y(m) = 0 for m < 0.
- R4: The product a·y is truncated toward minus infinity: floor(a·y / 2^15). For example, with a = 16384 and y = −1, the product term is −1.
- R5: When the sum leaves the signed 16-bit range, the output saturates to 32767 or −32768.
- R6: Suppose the odd member of a pair is accepted at edge E. Then y(2k) is on out_data with out_valid high in the cycle after E, and y(2k+1) follows in the next cycle.
- R7: Cycles with in_valid low do not advance the sample phase. Every completed pair produces exactly two outputs, in natural order.
- R8: The even lane's feedback is the odd-lane result from 5 pairs earlier. The odd lane's feedback is the even-lane result from 4 pairs earlier. As a result, an impulse at x(0) shows up again at y(9), y(18), and so on.
- R9: A reset in the middle of a stream discards a pending even sample and all history. The next samples are processed as a fresh stream that starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| coef | input | DW | Feedback coefficient a, signed Q1.15, held constant |
| in_valid | input | 1 | Marks an accepted input sample this cycle |
| in_data | input | DW | Input sample x(n), signed Q1.15 |
| out_valid | output | 1 | Marks a valid output sample this cycle |
| out_data | output | DW | Output sample y(n), signed Q1.15 |

## Verification
The properties assume that two input samples never complete a pair less than two cycles apart. This holds because each sample takes one cycle. They also assume that reset is the only way the input pairing is broken. The random stimulus inserts idle gaps of zero to two cycles and keeps the coefficient fixed inside each run. A segment that leaves an unpaired even sample always ends with a reset, so the balance between input and output counts stays within two. Saturation and truncation are reached through directed extreme values and are not left to chance.

// File: rtl/unf_pkg.sv
package unf_pkg;
   typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;

   // Pair-rate delay seen by a lane for a given sample lag.
   function automatic int fb_depth(input int lag, input bit odd_lane);
      if (lag % 2 == 0) return lag / 2;
      return odd_lane ? (lag - 1) / 2 : (lag + 1) / 2;
   endfunction

   // 1 when each lane's history comes from the other lane.
   function automatic bit fb_cross(input int lag);
      return (lag % 2) == 1;
   endfunction
endpackage

// File: rtl/unf_s2p.sv
module unf_s2p #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic [DW-1:0] x_even,
   output logic [DW-1:0] x_odd,
   output logic          pair_go
);
   import unf_pkg::*;

   phase_e        phase;
   logic [DW-1:0] hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_EVEN;
         hold  <= '0;
      end else if (in_valid) begin
         if (phase == PH_EVEN) begin
            hold  <= in_data;
            phase <= PH_ODD;
         end else begin
            phase <= PH_EVEN;
         end
      end
   end

   assign pair_go = in_valid && (phase == PH_ODD);
   assign x_even  = hold;
   assign x_odd   = in_data;
endmodule

// File: rtl/unf_lane.sv
module unf_lane #(
   parameter int DW   = 16,
   parameter int FRAC = 15
) (
   input  logic [DW-1:0] coef,
   input  logic [DW-1:0] fb,
   input  logic [DW-1:0] x,
   output logic [DW-1:0] y
);
   localparam int PW = 2 * DW;
   localparam int SW = PW + 1;
   localparam logic signed [SW-1:0] MAXV = SW'((1 <<< (DW - 1)) - 1);
   localparam logic signed [SW-1:0] MINV = -SW'(1 <<< (DW - 1));

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] scaled;
   logic signed [SW-1:0] sum;

   always_comb begin
      prod   = PW'($signed(coef)) * PW'($signed(fb));
      scaled = prod >>> FRAC;
      sum    = SW'(scaled) + SW'($signed(x));
      if (sum > MAXV)      y = MAXV[DW-1:0];
      else if (sum < MINV) y = MINV[DW-1:0];
      else                 y = sum[DW-1:0];
   end
endmodule

// File: rtl/unf_delay_line.sv
module unf_delay_line #(
   parameter int DW    = 16,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          shift,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] tap
);
   logic [DW-1:0] stage [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      end else if (shift) begin
         stage[0] <= d;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   assign tap = stage[DEPTH-1];
endmodule

// File: rtl/unf_p2s.sv
module unf_p2s #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pair_go,
   input  logic [DW-1:0] y_even,
   input  logic [DW-1:0] y_odd,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   logic          pend;
   logic [DW-1:0] pend_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         pend      <= 1'b0;
         pend_data <= '0;
      end else if (pair_go) begin
         out_valid <= 1'b1;
         out_data  <= y_even;
         pend      <= 1'b1;
         pend_data <= y_odd;
      end else if (pend) begin
         out_valid <= 1'b1;
         out_data  <= pend_data;
         pend      <= 1'b0;
      end else begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/unf2_iir.sv
module unf2_iir #(
   parameter int DW   = 16,
   parameter int FRAC = 15,
   parameter int LAG  = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] coef,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   import unf_pkg::*;

   localparam int  DEP_E = fb_depth(LAG, 1'b0);
   localparam int  DEP_O = fb_depth(LAG, 1'b1);
   localparam bit  CROSS = fb_cross(LAG);

   if (LAG < 2) begin : g_bad_lag
      $error("unf2_iir: LAG must be at least 2");
   end
   if (FRAC >= DW || DW < 2) begin : g_bad_fmt
      $error("unf2_iir: FRAC must be below DW");
   end

   logic [DW-1:0] x_even, x_odd;
   logic          pair_go;
   logic [DW-1:0] y_even, y_odd;
   logic [DW-1:0] fb_even, fb_odd;
   logic [DW-1:0] src_even, src_odd;

   unf_s2p #(.DW(DW)) u_s2p (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .x_even(x_even), .x_odd(x_odd), .pair_go(pair_go)
   );

   unf_lane #(.DW(DW), .FRAC(FRAC)) u_lane_e (
      .coef(coef), .fb(fb_even), .x(x_even), .y(y_even)
   );
   unf_lane #(.DW(DW), .FRAC(FRAC)) u_lane_o (
      .coef(coef), .fb(fb_odd), .x(x_odd), .y(y_odd)
   );

   if (CROSS) begin : g_cross
      assign src_even = y_odd;
      assign src_odd  = y_even;
   end else begin : g_self
      assign src_even = y_even;
      assign src_odd  = y_odd;
   end

   unf_delay_line #(.DW(DW), .DEPTH(DEP_E)) u_dl_e (
      .clk(clk), .rst(rst), .shift(pair_go), .d(src_even), .tap(fb_even)
   );
   unf_delay_line #(.DW(DW), .DEPTH(DEP_O)) u_dl_o (
      .clk(clk), .rst(rst), .shift(pair_go), .d(src_odd), .tap(fb_odd)
   );

   unf_p2s #(.DW(DW)) u_p2s (
      .clk(clk), .rst(rst), .pair_go(pair_go), .y_even(y_even), .y_odd(y_odd),
      .out_valid(out_valid), .out_data(out_data)
   );
endmodule

// File: rtl/unf2_iir_chk.sv
module unf2_iir_chk (
   input logic clk,
   input logic rst,
   input logic in_valid,
   input logic out_valid
);
   logic       opar;
   logic [2:0] bal;

   always_ff @(posedge clk) begin
      if (rst) begin
         opar <= 1'b0;
         bal  <= '0;
      end else begin
         if (out_valid) opar <= ~opar;
         bal <= bal + 3'(in_valid) - 3'(out_valid);
      end
   end

   // R1: the cycle after a reset edge carries no output
   a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |-> !out_valid);

   // R2: the first output of a pair needs an accepted input in the cycle before
   a_r2_needs_input: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !opar) |-> $past(in_valid));

   // R6: the second output follows the first with no gap
   a_r6_back_to_back: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !opar) |=> out_valid);

   // R7: accepted inputs never run more than one pair ahead of outputs
   a_r7_balance: assert property (@(posedge clk) disable iff (rst) bal <= 3'd2);
endmodule

bind unf2_iir unf2_iir_chk u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid)
);

// File: tb/sim_unf2_iir.sv
module sim_unf2_iir;
   localparam int DW  = 16;
   localparam int LAG = 9;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] coef = '0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;

   unf2_iir u0 (
      .clk(clk), .rst(rst), .coef(coef), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   always #2.5 clk = ~clk;

   int    nchk = 0;
   int    nfail = 0;
   string cur_req = "R3";
   int    expq[$];
   int    hist [1024];
   int    nidx = 0;
   bit    mon_par = 1'b0;
   int    cyc = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_step(input int x);
      int a, yd, p, s;
      a  = $signed(coef);
      yd = (nidx >= LAG) ? hist[nidx-LAG] : 0;
      p  = (a * yd) >>> 15;
      s  = p + x;
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      hist[nidx] = s;
      nidx++;
      return s;
   endfunction

   task automatic send(input int x);
      in_valid = 1'b1;
      in_data  = DW'(x);
      expq.push_back(model_step(x));
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic do_reset();
      rst = 1'b1; in_valid = 1'b0;
      idle(3);
      rst = 1'b0;
      expq.delete();
      nidx = 0;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);
      @(posedge clk); #1;
   endtask

   task automatic drain(input string req);
      idle(6);
      check(expq.size() == 0, req, expq.size(), 0);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst) mon_par <= 1'b0;
      else begin
         if (mon_par && !out_valid) check(1'b0, "R6", 0, 1);
         if (out_valid) begin
            mon_par <= ~mon_par;
            if (expq.size() == 0) check(1'b0, "R7", 1, 0);
            else begin
               int e;
               e = expq.pop_front();
               check($signed(out_data) == e, cur_req, $signed(out_data), e);
            end
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      coef = 16'sd0;
      do_reset();

      // R2: lone even sample produces nothing
      cur_req = "R2";
      send(1234);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R2", int'(out_valid), 0);
      end
      @(posedge clk); #1;
      send(-77);
      drain("R2");

      // R6: exact output cycles after the pair completes
      cur_req = "R6";
      do_reset();
      send(100);
      send(-200);
      @(negedge clk);
      check(out_valid && $signed(out_data) == 100, "R6", $signed(out_data), 100);
      @(negedge clk);
      check(out_valid && $signed(out_data) == -200, "R6", $signed(out_data), -200);
      @(negedge clk);
      check(out_valid == 1'b0, "R6", int'(out_valid), 0);
      @(posedge clk); #1;
      drain("R6");

      // R8: impulse feeds back across lanes
      cur_req = "R8";
      coef = 16'sd16384;
      do_reset();
      send(16384);
      for (int i = 1; i < 40; i++) send(0);
      drain("R8");

      // R4: truncation toward minus infinity
      cur_req = "R4";
      do_reset();
      send(-1);
      for (int i = 1; i < 20; i++) send(0);
      drain("R4");

      // R5: saturation at both limits
      cur_req = "R5";
      coef = 16'sh7FFF;
      do_reset();
      for (int i = 0; i < 30; i++) send(32767);
      drain("R5");
      do_reset();
      for (int i = 0; i < 30; i++) send(-32768);
      drain("R5");

      // R3/R7: random data with idle gaps
      cur_req = "R3";
      for (int run = 0; run < 2; run++) begin
         coef = DW'($urandom);
         do_reset();
         for (int i = 0; i < 240; i++) begin
            send(int'($signed(DW'($urandom))));
            idle($urandom_range(0, 2));
         end
         drain("R7");
      end

      // R9: reset mid-stream with a pending even sample
      cur_req = "R9";
      coef = 16'sd20000;
      do_reset();
      for (int i = 0; i < 11; i++) send(3000 + i * 100);
      idle(6);
      check(expq.size() == 1, "R9", expq.size(), 1);
      do_reset();
      for (int i = 0; i < 24; i++) send(-500 * i);
      drain("R9");

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule